// File: doc/BRIEF.md
# Chip Security State Monitor

This block follows the security state of a chip from power-on reset. While it is idle, software may program a response policy. A boot-start strobe then moves the monitor into a checking state, where it waits for the secure-boot verdict over a ready/valid handshake. A passing verdict puts the monitor in the trusted state. A failing verdict puts it in a non-secure state, and it stays there until the next reset.

Violations are watched only in the trusted state. The violation sources are:
- a set of tamper lines,
- a self-test failure line,
- a fuse integrity check, which recomputes check bits over the fuse word and compares them with the stored ones.

Each source has its own 2-bit action field. The actions are, in order of strength: record only, master-key lockout, lockout with an interrupt, and lockout with a fixed-length chip-reset request. Any action stronger than record-only drives the monitor into a failure state. The failure state holds until reset.

Top module: `secmon_top`

## Requirements
- R1: After rst_n is released, state_o is 0 (idle), and key_lock_o, chip_rst_o, irq_o, fired_o, policy_o and boot_ready_o are all 0.
- R2: A pol_we write loads pol_wdata into policy_o one cycle later, but only while state_o is idle (0). In every other state, writes leave policy_o unchanged.
- R3: State codes are 0 idle, 1 check, 2 trusted, 3 non-secure and 4 fail.
  - boot_start in idle moves the monitor to check.
  - boot_ready_o is high only in check.
  - boot_valid in check moves the monitor to trusted when boot_pass is 1, and to non-secure when boot_pass is 0.
  - boot_valid in any other state has no effect.
  - Trusted is reachable only through a passing verdict.
- R4: Violations in the idle, check, non-secure or fail state change no output.
- R5: Source i uses policy bits [2i+1:2i]. Source order is: tamper lines 0..NUM_TAMPER-1, then self-test, then fuse check. The actions for a violation seen in trusted are:
  - 0: record only, and the monitor stays trusted.
  - 1: key lockout and fail.
  - 2: key lockout, a one-cycle irq_o and fail.
  - 3: key lockout, a chip-reset request and fail.
  - All outputs change on the clock edge that samples the violation.
- R6: When several sources fire in the same cycle, the strongest of their actions is taken, and every one of them is recorded.
- R7: key_lock_o never falls except through rst_n.
- R8: chip_rst_o is high for exactly RST_LEN (16) consecutive cycles per reset action.
- R9: The fail state is left only through rst_n.
- R10: Check bit k of the fuse word is the XOR of every data bit j with j mod ECC_W == k. While fuse_valid is high, any difference from fuse_ecc is a violation of the fuse source. While fuse_valid is low, no fuse comparison is made.
- R11: fired_o bit i is set when source i fires in trusted, and stays set until reset.
- R12: irq_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pol_we | input | 1 | Policy write strobe |
| pol_wdata | input | 2*NUM_SRC | Policy value, 2 bits per source |
| boot_start | input | 1 | Secure boot begins |
| boot_valid | input | 1 | Boot verdict valid |
| boot_pass | input | 1 | Boot verdict: 1 pass, 0 fail |
| boot_ready_o | output | 1 | Ready for a boot verdict |
| tamper_i | input | NUM_TAMPER | Tamper flags |
| selftest_fail_i | input | 1 | Hardware self-test failure |
| fuse_valid | input | 1 | Fuse word and check bits are valid |
| fuse_data | input | FUSE_W | Fuse word |
| fuse_ecc | input | ECC_W | Stored fuse check bits |
| key_lock_o | output | 1 | Master-key lockout, sticky |
| chip_rst_o | output | 1 | Chip reset request pulse |
| irq_o | output | 1 | Violation interrupt pulse |
| state_o | output | 3 | Current state code |
| fired_o | output | NUM_SRC | Sources that have fired |
| policy_o | output | 2*NUM_SRC | Current policy |

## Verification
Each internal fault shows at the ports on the clock edge after the stimulus:
- A wrong state code appears directly on state_o.
- A misdecoded policy field shows up as the wrong mix of key_lock_o, irq_o and chip_rst_o.
- A mis-mapped source sets the wrong fired_o bit.

The sweep covers every source with every action. Two faults take longer to expose: a counter that stops early or runs late is caught only when chip_rst_o is counted over the full pulse, and a sticky bit that decays only after key_lock_o and fired_o are watched across later cycles and further stimulus.

// File: rtl/secmon_pkg.sv
package secmon_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_TRUSTED = 3'd2,
        ST_NONSEC  = 3'd3,
        ST_FAIL    = 3'd4
    } sm_state_e;

    typedef enum logic [1:0] {
        ACT_RECORD   = 2'd0,
        ACT_LOCK     = 2'd1,
        ACT_LOCK_IRQ = 2'd2,
        ACT_RESET    = 2'd3
    } act_e;
endpackage

// File: rtl/secmon_fuse_chk.sv
module secmon_fuse_chk #(
    parameter int FUSE_W = 16,
    parameter int ECC_W  = 4
) (
    input  logic              valid,
    input  logic [FUSE_W-1:0] data,
    input  logic [ECC_W-1:0]  ecc,
    output logic              mismatch
);
    logic [ECC_W-1:0] calc;

    for (genvar g = 0; g < ECC_W; g++) begin : g_grp
        always_comb begin
            calc[g] = 1'b0;
            for (int j = 0; j < FUSE_W; j++) begin
                if ((j % ECC_W) == g) calc[g] = calc[g] ^ data[j];
            end
        end
    end

    assign mismatch = valid && (calc != ecc);
endmodule

// File: rtl/secmon_policy_dec.sv
module secmon_policy_dec
    import secmon_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0]   fire,
    input  logic [2*NUM_SRC-1:0] policy,
    output logic                 any_fire,
    output act_e                 worst
);
    logic [1:0] act_src [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign act_src[i] = fire[i] ? policy[2*i +: 2] : 2'd0;
    end

    always_comb begin
        logic [1:0] m;
        m = 2'd0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_src[i] > m) m = act_src[i];
        end
        worst = act_e'(m);
    end

    assign any_fire = |fire;
endmodule

// File: rtl/secmon_rst_pulse.sv
module secmon_rst_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/secmon_top.sv
module secmon_top
    import secmon_pkg::*;
#(
    parameter int NUM_TAMPER = 2,
    parameter int FUSE_W     = 16,
    parameter int ECC_W      = 4,
    parameter int RST_LEN    = 16,
    localparam int NUM_SRC   = NUM_TAMPER + 2,
    localparam int POL_W     = 2 * NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol_we,
    input  logic [POL_W-1:0]  pol_wdata,
    input  logic              boot_start,
    input  logic              boot_valid,
    input  logic              boot_pass,
    output logic              boot_ready_o,
    input  logic [NUM_TAMPER-1:0] tamper_i,
    input  logic              selftest_fail_i,
    input  logic              fuse_valid,
    input  logic [FUSE_W-1:0] fuse_data,
    input  logic [ECC_W-1:0]  fuse_ecc,
    output logic              key_lock_o,
    output logic              chip_rst_o,
    output logic              irq_o,
    output logic [2:0]        state_o,
    output logic [NUM_SRC-1:0] fired_o,
    output logic [POL_W-1:0]  policy_o
);
    localparam int SRC_SELFTEST = NUM_TAMPER;
    localparam int SRC_FUSE     = NUM_TAMPER + 1;

    typedef struct packed {
        sm_state_e          state;
        logic [POL_W-1:0]   policy;
        logic [NUM_SRC-1:0] fired;
        logic               key_lock;
        logic               irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               fuse_mm;
    logic [NUM_SRC-1:0] viol;
    logic               viol_any;
    act_e               worst;
    logic               pulse_start;

    secmon_fuse_chk #(.FUSE_W(FUSE_W), .ECC_W(ECC_W)) u_fuse (
        .valid   (fuse_valid),
        .data    (fuse_data),
        .ecc     (fuse_ecc),
        .mismatch(fuse_mm)
    );

    always_comb begin
        viol = '0;
        viol[NUM_TAMPER-1:0] = tamper_i;
        viol[SRC_SELFTEST]   = selftest_fail_i;
        viol[SRC_FUSE]       = fuse_mm;
    end

    secmon_policy_dec #(.NUM_SRC(NUM_SRC)) u_dec (
        .fire    (viol),
        .policy  (ctl_q.policy),
        .any_fire(viol_any),
        .worst   (worst)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.irq   = 1'b0;
        pulse_start = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (pol_we)     ctl_d.policy = pol_wdata;
                if (boot_start) ctl_d.state  = ST_CHECK;
            end
            ST_CHECK: begin
                if (boot_valid) ctl_d.state = boot_pass ? ST_TRUSTED : ST_NONSEC;
            end
            ST_TRUSTED: begin
                if (viol_any) begin
                    ctl_d.fired = ctl_q.fired | viol;
                    unique case (worst)
                        ACT_RECORD: ;
                        ACT_LOCK: begin
                            ctl_d.key_lock = 1'b1;
                            ctl_d.state    = ST_FAIL;
                        end
                        ACT_LOCK_IRQ: begin
                            ctl_d.key_lock = 1'b1;
                            ctl_d.irq      = 1'b1;
                            ctl_d.state    = ST_FAIL;
                        end
                        ACT_RESET: begin
                            ctl_d.key_lock = 1'b1;
                            ctl_d.state    = ST_FAIL;
                            pulse_start    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_IDLE;
            ctl_q.policy   <= '0;
            ctl_q.fired    <= '0;
            ctl_q.key_lock <= 1'b0;
            ctl_q.irq      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    secmon_rst_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .start(pulse_start),
        .pulse(chip_rst_o)
    );

    assign boot_ready_o = (ctl_q.state == ST_CHECK);
    assign key_lock_o   = ctl_q.key_lock;
    assign irq_o        = ctl_q.irq;
    assign state_o      = ctl_q.state;
    assign fired_o      = ctl_q.fired;
    assign policy_o     = ctl_q.policy;
endmodule

// File: rtl/secmon_chk.sv
module secmon_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boot_valid,
    input logic               boot_pass,
    input logic               key_lock_o,
    input logic               chip_rst_o,
    input logic               irq_o,
    input logic [2:0]         state_o,
    input logic [NUM_SRC-1:0] fired_o,
    input logic [2*NUM_SRC-1:0] policy_o
);
    assert_key_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_lock_o |=> key_lock_o);

    assert_trusted_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd2 && !(state_o == 3'd1 && boot_valid && boot_pass)) |=> state_o != 3'd2);

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 |=> state_o == 3'd4);

    assert_policy_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 3'd0 |=> $stable(policy_o));

    assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (key_lock_o && state_o == 3'd4));

    assert_rst_in_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> (key_lock_o && state_o == 3'd4));

    assert_fired_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_o != '0) |=> ((fired_o & $past(fired_o)) == $past(fired_o)));
endmodule

bind secmon_top secmon_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_valid(boot_valid),
    .boot_pass (boot_pass),
    .key_lock_o(key_lock_o),
    .chip_rst_o(chip_rst_o),
    .irq_o     (irq_o),
    .state_o   (state_o),
    .fired_o   (fired_o),
    .policy_o  (policy_o)
);

// File: tb/secmon_top_tb.sv
`timescale 1ns/1ps
module secmon_top_tb;
    localparam int NT = 2, FW = 16, EW = 4, RL = 16;
    localparam int NS = NT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pol_we = 1'b0;
    logic [2*NS-1:0] pol_wdata = '0;
    logic boot_start = 1'b0, boot_valid = 1'b0, boot_pass = 1'b0;
    logic boot_ready_o;
    logic [NT-1:0] tamper_i = '0;
    logic selftest_fail_i = 1'b0;
    logic fuse_valid = 1'b1;
    logic [FW-1:0] fuse_data = 16'hA5C3;
    logic [EW-1:0] fuse_ecc;
    logic key_lock_o, chip_rst_o, irq_o;
    logic [2:0] state_o;
    logic [NS-1:0] fired_o;
    logic [2*NS-1:0] policy_o;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    secmon_top u_dut (
        .clk(clk), .rst_n(rst_n), .pol_we(pol_we), .pol_wdata(pol_wdata),
        .boot_start(boot_start), .boot_valid(boot_valid), .boot_pass(boot_pass),
        .boot_ready_o(boot_ready_o), .tamper_i(tamper_i), .selftest_fail_i(selftest_fail_i),
        .fuse_valid(fuse_valid), .fuse_data(fuse_data), .fuse_ecc(fuse_ecc),
        .key_lock_o(key_lock_o), .chip_rst_o(chip_rst_o), .irq_o(irq_o),
        .state_o(state_o), .fired_o(fired_o), .policy_o(policy_o)
    );

    function automatic logic [EW-1:0] ecc_of(input logic [FW-1:0] d);
        logic [EW-1:0] e = '0;
        for (int j = 0; j < FW; j++) e[j % EW] ^= d[j];
        return e;
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        fuse_data = 16'hA5C3;
        fuse_ecc  = ecc_of(fuse_data);
        fuse_valid = 1'b1;
        tamper_i = '0; selftest_fail_i = 1'b0;
        rst_n = 1'b0; cyc(); cyc();
        rst_n = 1'b1; cyc();
    endtask

    task automatic set_policy(input logic [2*NS-1:0] p);
        pol_we = 1'b1; pol_wdata = p; cyc(); pol_we = 1'b0;
    endtask

    task automatic boot(input logic pass);
        boot_start = 1'b1; cyc(); boot_start = 1'b0;
        boot_valid = 1'b1; boot_pass = pass; cyc(); boot_valid = 1'b0;
    endtask

    task automatic fire(input logic [NS-1:0] m);
        tamper_i = m[NT-1:0];
        selftest_fail_i = m[NT];
        if (m[NT+1]) fuse_data = fuse_data ^ 16'h0001;
        cyc();
        tamper_i = '0; selftest_fail_i = 1'b0;
        fuse_data = 16'hA5C3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(state_o == 3'd0 && !key_lock_o && !chip_rst_o && !irq_o && fired_o == '0
            && policy_o == '0 && !boot_ready_o, "R1", {state_o, fired_o, policy_o}, 0);

        // R3 verdict ignored in idle, ready only in check
        boot_valid = 1'b1; boot_pass = 1'b1; cyc(); boot_valid = 1'b0;
        chk(state_o == 3'd0, "R3", state_o, 0);
        boot_start = 1'b1; cyc(); boot_start = 1'b0;
        chk(state_o == 3'd1 && boot_ready_o, "R3", {state_o, boot_ready_o}, 3);
        // R4 violation in check ignored
        fire('1);
        chk(!key_lock_o && fired_o == '0 && state_o == 3'd1, "R4", {key_lock_o, fired_o}, 0);

        // R5/R7/R8/R11/R12 sweep over every source and action
        for (int s = 0; s < NS; s++) begin
            for (int a = 0; a < 4; a++) begin
                logic [2*NS-1:0] p;
                int hi;
                do_reset();
                p = '0; p[2*s +: 2] = 2'(a);
                set_policy(p);
                chk(policy_o == p, "R2", policy_o, p);
                boot(1'b1);
                chk(state_o == 3'd2 && !boot_ready_o, "R3", state_o, 2);
                fire(NS'(1) << s);
                chk(fired_o == (NS'(1) << s), "R11", fired_o, NS'(1) << s);
                chk(state_o == ((a == 0) ? 3'd2 : 3'd4), "R5", state_o, (a == 0) ? 2 : 4);
                chk(key_lock_o == (a != 0), "R5", key_lock_o, a != 0);
                chk(irq_o == (a == 2), "R5", irq_o, a == 2);
                chk(chip_rst_o == (a == 3), "R5", chip_rst_o, a == 3);
                hi = chip_rst_o ? 1 : 0;
                cyc();
                chk(!irq_o, "R12", irq_o, 0);
                if (chip_rst_o) hi++;
                for (int k = 0; k < 24; k++) begin
                    cyc();
                    if (chip_rst_o) hi++;
                end
                chk(hi == ((a == 3) ? RL : 0), "R8", hi, (a == 3) ? RL : 0);
                chk(key_lock_o == (a != 0), "R7", key_lock_o, a != 0);
            end
        end

        // R7 cleared only by reset, R9 fail sticky
        do_reset();
        set_policy(8'h01); boot(1'b1); fire(4'b0001);
        chk(state_o == 3'd4, "R9", state_o, 4);
        boot_start = 1'b1; cyc(); boot_start = 1'b0;
        boot_valid = 1'b1; boot_pass = 1'b1; cyc(); boot_valid = 1'b0;
        chk(state_o == 3'd4 && key_lock_o, "R9", state_o, 4);
        set_policy(8'hFF);
        chk(policy_o == 8'h01, "R2", policy_o, 8'h01);
        fire(4'b1110);
        chk(fired_o == 4'b0001 && !chip_rst_o, "R4", fired_o, 1);
        do_reset();
        chk(!key_lock_o && state_o == 3'd0, "R7", key_lock_o, 0);

        // R4 non-secure path ignores violations and writes
        do_reset();
        set_policy(8'hFF); boot(1'b0);
        chk(state_o == 3'd3, "R3", state_o, 3);
        fire('1);
        chk(!key_lock_o && !chip_rst_o && fired_o == '0, "R4", {key_lock_o, fired_o}, 0);
        set_policy(8'h00);
        chk(policy_o == 8'hFF, "R2", policy_o, 8'hFF);

        // R6 strongest action wins, all recorded
        do_reset();
        set_policy(8'b00_00_11_01); boot(1'b1); fire(4'b0011);
        chk(chip_rst_o && key_lock_o && !irq_o && fired_o == 4'b0011, "R6", fired_o, 3);
        do_reset();
        set_policy(8'b00_10_00_00); boot(1'b1); fire(4'b0101);
        chk(irq_o && key_lock_o && !chip_rst_o && fired_o == 4'b0101, "R6", fired_o, 5);

        // R11 record-only accumulation
        do_reset();
        boot(1'b1); fire(4'b0100); fire(4'b0010);
        chk(fired_o == 4'b0110 && state_o == 3'd2 && !key_lock_o, "R11", fired_o, 6);

        // R10 single-bit flips in data and check bits
        for (int b = 0; b < FW + EW; b++) begin
            do_reset();
            set_policy(8'b01_00_00_00); boot(1'b1);
            if (b < FW) fuse_data[b] = ~fuse_data[b];
            else        fuse_ecc[b-FW] = ~fuse_ecc[b-FW];
            cyc();
            chk(key_lock_o && fired_o == 4'b1000, "R10", fired_o, 8);
            fuse_data = 16'hA5C3; fuse_ecc = ecc_of(fuse_data);
        end
        // R10 no check while fuse_valid low, consistent words pass
        do_reset();
        set_policy(8'b01_00_00_00); boot(1'b1);
        fuse_valid = 1'b0; fuse_data = 16'h0F0F; cyc();
        chk(!key_lock_o && fired_o == '0, "R10", fired_o, 0);
        fuse_valid = 1'b1; fuse_data = 16'h1234; fuse_ecc = ecc_of(16'h1234); cyc();
        chk(!key_lock_o && state_o == 3'd2, "R10", state_o, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule